// File: doc/BRIEF.md
# Page Translation Buffer with Hardware Table Walk

This block keeps a small, fully associative set of cached page table entries. It maps a virtual page number to a physical page number. Every cached entry is compared with the incoming virtual page number in the same cycle. On a hit, the physical page number is returned one cycle after the request is accepted. On the same edge the entry's reference bit is set, and its dirty bit is set as well when the request is a write.

On a miss, a walker reads the entry from a one-level page table in word-addressed memory. The address of that entry is the table base input plus the virtual page number. An entry that is marked not present is reported to software as a page fault, and nothing is cached. A present entry is installed in a victim slot and the lookup is then repeated, which returns the translation.

The victim is the lowest slot whose reference bit is clear. When every reference bit is set, a rotating pointer picks the victim instead. If the victim's reference or dirty bit was set while it was cached, the victim is first written back to its table slot. A clear pulse wipes all reference bits, standing in for the periodic sweep done by the operating system.

Top module: `ptx_tlb`

## Requirements
- R1: When `rst` is high (synchronous), the next clock edge gives `resp_valid`=0, `mem_req`=0 and `req_ready`=1, and every slot becomes empty, so the first access to any page after reset is a miss.
- R2: A request accepted while `req_ready`=1 that matches a cached entry gives `resp_valid`=1 with the cached `resp_ppn` and `resp_fault`=0 in the very next cycle, and makes no memory access.
- R3: On a miss, the block reads word address `ptbr + vpn` and holds `req_ready` low until its response. It installs the entry and repeats the lookup, then responds with the entry's physical page number. At most one slot ever matches a given page.
- R4: A page table entry has PPN_W+3 bits. Bits [PPN_W-1:0] hold the physical page number, bit PPN_W is the reference bit, bit PPN_W+1 is the dirty bit and bit PPN_W+2 is the present bit.
- R5: A loaded entry whose present bit is 0 gives `resp_valid`=1 with `resp_fault`=1 and `resp_ppn`=0. It is not cached, so a repeat access walks again, and it causes no memory write.
- R6: Every access sets the entry's reference bit, and a write access also sets its dirty bit. Both bits show in the data of that entry's later write-back.
- R7: A one-cycle pulse on `ref_clear` clears the reference bit of every slot. This clearing alone does not make an entry eligible for write-back.
- R8: The victim is the lowest-numbered slot whose reference bit is 0, and empty slots count as 0. When all reference bits are 1, a rotating pointer chooses the victim. The pointer starts at slot 0 after reset and advances by one each time it is used.
- R9: A victim whose reference or dirty bit was set by an access while it was cached is first written to `ptbr + victim vpn`. The written data has the present bit at 1 and holds the victim's current reference and dirty bits. A victim with no such change is replaced without any write.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged from the time a request is raised until `mem_ack` is seen. Each walk issues exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when req_ready is 1 |
| req_ready | output | 1 | Block is idle and can take a request |
| req_vpn | input | VPN_W (10) | Virtual page number to translate |
| req_write | input | 1 | Request is a write access |
| ptbr | input | PA_W (16) | Word address of the page table base |
| ref_clear | input | 1 | Pulse that clears every reference bit |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ppn | output | PPN_W (12) | Physical page number (0 on fault) |
| resp_fault | output | 1 | Page not present |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | PA_W (16) | Memory word address |
| mem_wdata | output | PPN_W+3 (15) | Entry written back |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | PPN_W+3 (15) | Entry read, valid with mem_ack |

## Verification
The properties assume the following about memory:
- `mem_ack` is raised only while a request is pending.
- Each request gets exactly one acknowledge.
- The table base does not move during a walk.

The stimulus meets these assumptions with a fixed-latency memory model that answers each request once, and with a constant `ptbr`. Requests are offered only while `req_ready` is 1 and are dropped in the cycle after acceptance. This keeps the hit-latency and single-match properties within the cases they were written for.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [2:0] {
    W_IDLE,
    W_READ,
    W_BACK,
    W_FILL,
    W_RETRY
  } walk_st_t;

  // status bit positions above the physical page number field
  localparam int unsigned REF_OFS = 0;
  localparam int unsigned DRT_OFS = 1;
  localparam int unsigned PRS_OFS = 2;
endpackage

// File: rtl/ptx_cam.sv
module ptx_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 10,
  parameter int unsigned PPN_W   = 12,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PPN_W-1:0]   hit_ppn,
  input  logic               upd_en,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               upd_wr,
  input  logic               ins_en,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [PPN_W-1:0]   ins_ppn,
  input  logic               ins_ref,
  input  logic               ins_dirty,
  input  logic               ref_clr,
  output logic [ENTRIES-1:0] ref_vec,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic               rd_chg,
  output logic               rd_ref,
  output logic               rd_dirty,
  output logic [VPN_W-1:0]   rd_vpn,
  output logic [PPN_W-1:0]   rd_ppn
);
  logic [VPN_W-1:0]   vpn_arr [ENTRIES];
  logic [PPN_W-1:0]   ppn_arr [ENTRIES];
  logic [ENTRIES-1:0] val_vec;
  logic [ENTRIES-1:0] chg_vec;
  logic [ENTRIES-1:0] drt_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic             v_q, r_q, d_q, c_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             ins_me, upd_me;

    assign ins_me = ins_en && (ins_idx == IDX_W'(i));
    assign upd_me = upd_en && (upd_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        d_q <= 1'b0;
        c_q <= 1'b0;
      end else if (ins_me) begin
        v_q <= 1'b1;
        r_q <= ins_ref;
        d_q <= ins_dirty;
        c_q <= 1'b0;
      end else if (upd_me) begin
        r_q <= 1'b1;
        d_q <= d_q | upd_wr;
        c_q <= c_q | ~r_q | (upd_wr & ~d_q);
      end else if (ref_clr) begin
        r_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (ins_me) begin
        vpn_q <= ins_vpn;
        ppn_q <= ins_ppn;
      end
    end

    assign vpn_arr[i]   = vpn_q;
    assign ppn_arr[i]   = ppn_q;
    assign val_vec[i]   = v_q;
    assign ref_vec[i]   = r_q;
    assign drt_vec[i]   = d_q;
    assign chg_vec[i]   = c_q;
    assign match_vec[i] = v_q && (vpn_q == lk_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit      = |match_vec;
  assign hit_ppn  = ppn_arr[hit_idx];
  assign rd_valid = val_vec[rd_idx];
  assign rd_chg   = chg_vec[rd_idx];
  assign rd_ref   = ref_vec[rd_idx];
  assign rd_dirty = drt_vec[rd_idx];
  assign rd_vpn   = vpn_arr[rd_idx];
  assign rd_ppn   = ppn_arr[rd_idx];
endmodule

// File: rtl/ptx_victim.sv
module ptx_victim #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] ref_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] first_clr;
  logic             all_set;

  always_comb begin
    first_clr = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ref_vec[i]) first_clr = IDX_W'(i);
    end
  end

  assign all_set    = &ref_vec;
  assign victim_idx = all_set ? rr_q : first_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && all_set) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/ptx_walker.sv
module ptx_walker
  import ptx_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 10,
  parameter int unsigned PPN_W   = 12,
  parameter int unsigned PA_W    = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned PTE_W  = PPN_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  input  logic [PA_W-1:0]  ptbr,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             hit,
  input  logic [PPN_W-1:0] hit_ppn,
  output logic             upd_en,
  output logic             upd_wr,
  input  logic [IDX_W-1:0] victim_idx,
  input  logic             vic_valid,
  input  logic             vic_chg,
  input  logic             vic_ref,
  input  logic             vic_dirty,
  input  logic [VPN_W-1:0] vic_vpn,
  input  logic [PPN_W-1:0] vic_ppn,
  output logic             take,
  output logic             ins_en,
  output logic [IDX_W-1:0] ins_idx,
  output logic [VPN_W-1:0] ins_vpn,
  output logic [PPN_W-1:0] ins_ppn,
  output logic             ins_ref,
  output logic             ins_dirty,
  output logic             resp_valid,
  output logic [PPN_W-1:0] resp_ppn,
  output logic             resp_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  walk_st_t         st;
  logic [VPN_W-1:0] held_vpn;
  logic             held_wr;
  logic [PPN_W-1:0] ld_ppn;
  logic             ld_ref, ld_dirty;
  logic [IDX_W-1:0] vic_q;
  logic             ld_present;

  assign req_ready  = (st == W_IDLE);
  assign lk_vpn     = (st == W_IDLE) ? req_vpn : held_vpn;
  assign upd_en     = hit && (((st == W_IDLE) && req_valid) || (st == W_RETRY));
  assign upd_wr     = (st == W_IDLE) ? req_write : held_wr;
  assign ld_present = mem_rdata[PPN_W + PRS_OFS];
  assign take       = (st == W_READ) && mem_ack && ld_present;
  assign ins_en     = (st == W_FILL);
  assign ins_idx    = vic_q;
  assign ins_vpn    = held_vpn;
  assign ins_ppn    = ld_ppn;
  assign ins_ref    = ld_ref;
  assign ins_dirty  = ld_dirty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= W_IDLE;
      resp_valid <= 1'b0;
      resp_ppn   <= '0;
      resp_fault <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      held_vpn   <= '0;
      held_wr    <= 1'b0;
      ld_ppn     <= '0;
      ld_ref     <= 1'b0;
      ld_dirty   <= 1'b0;
      vic_q      <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (st)
        W_IDLE: begin
          if (req_valid) begin
            held_vpn <= req_vpn;
            held_wr  <= req_write;
            if (hit) begin
              resp_valid <= 1'b1;
              resp_fault <= 1'b0;
              resp_ppn   <= hit_ppn;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= ptbr + PA_W'(req_vpn);
              st       <= W_READ;
            end
          end
        end
        W_READ: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            ld_ppn   <= mem_rdata[PPN_W-1:0];
            ld_ref   <= mem_rdata[PPN_W + REF_OFS];
            ld_dirty <= mem_rdata[PPN_W + DRT_OFS];
            vic_q    <= victim_idx;
            if (!ld_present) begin
              resp_valid <= 1'b1;
              resp_fault <= 1'b1;
              resp_ppn   <= '0;
              st         <= W_IDLE;
            end else if (vic_valid && vic_chg) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= ptbr + PA_W'(vic_vpn);
              mem_wdata <= {1'b1, vic_dirty, vic_ref, vic_ppn};
              st        <= W_BACK;
            end else begin
              st <= W_FILL;
            end
          end
        end
        W_BACK: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= W_FILL;
          end
        end
        W_FILL: st <= W_RETRY;
        W_RETRY: begin
          if (hit) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_ppn   <= hit_ppn;
            st         <= W_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ptbr + PA_W'(held_vpn);
            st       <= W_READ;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptx_tlb.sv
module ptx_tlb #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 10,
  parameter int unsigned PPN_W   = 12,
  parameter int unsigned PA_W    = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned PTE_W  = PPN_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  input  logic [PA_W-1:0]  ptbr,
  input  logic             ref_clear,
  output logic             resp_valid,
  output logic [PPN_W-1:0] resp_ppn,
  output logic             resp_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] match_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   hit_ppn;
  logic               upd_en, upd_wr;
  logic               ins_en, ins_ref, ins_dirty;
  logic [IDX_W-1:0]   ins_idx;
  logic [VPN_W-1:0]   ins_vpn;
  logic [PPN_W-1:0]   ins_ppn;
  logic [ENTRIES-1:0] ref_vec;
  logic [IDX_W-1:0]   victim_idx;
  logic               take;
  logic               vic_valid, vic_chg, vic_ref, vic_dirty;
  logic [VPN_W-1:0]   vic_vpn;
  logic [PPN_W-1:0]   vic_ppn;

  ptx_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .match_vec(match_vec),
    .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn),
    .upd_en(upd_en), .upd_idx(hit_idx), .upd_wr(upd_wr),
    .ins_en(ins_en), .ins_idx(ins_idx), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
    .ins_ref(ins_ref), .ins_dirty(ins_dirty), .ref_clr(ref_clear),
    .ref_vec(ref_vec), .rd_idx(victim_idx), .rd_valid(vic_valid),
    .rd_chg(vic_chg), .rd_ref(vic_ref), .rd_dirty(vic_dirty),
    .rd_vpn(vic_vpn), .rd_ppn(vic_ppn)
  );

  ptx_victim #(.ENTRIES(ENTRIES)) u_vic (
    .clk(clk), .rst(rst), .ref_vec(ref_vec), .take(take),
    .victim_idx(victim_idx)
  );

  ptx_walker #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PA_W(PA_W)) u_walk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_write(req_write), .ptbr(ptbr), .lk_vpn(lk_vpn),
    .hit(hit), .hit_ppn(hit_ppn), .upd_en(upd_en), .upd_wr(upd_wr),
    .victim_idx(victim_idx), .vic_valid(vic_valid), .vic_chg(vic_chg),
    .vic_ref(vic_ref), .vic_dirty(vic_dirty), .vic_vpn(vic_vpn),
    .vic_ppn(vic_ppn), .take(take), .ins_en(ins_en), .ins_idx(ins_idx),
    .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_ref(ins_ref),
    .ins_dirty(ins_dirty), .resp_valid(resp_valid), .resp_ppn(resp_ppn),
    .resp_fault(resp_fault), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/ptx_tlb_chk.sv
module ptx_tlb_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PPN_W   = 12,
  parameter int unsigned PA_W    = 16,
  localparam int unsigned PTE_W  = PPN_W + 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               hit,
  input logic [ENTRIES-1:0] match_vec,
  input logic               resp_valid,
  input logic               resp_fault,
  input logic [PPN_W-1:0]   resp_ppn,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [PA_W-1:0]    mem_addr,
  input logic [PTE_W-1:0]   mem_wdata
);
  // R1: reset state appears on the edge after reset is sampled
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!resp_valid && !mem_req && req_ready));

  // R2: a hit answers in the next cycle without fault
  p_hit_next_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && hit) |=> (resp_valid && !resp_fault));

  // R3: never more than one slot matches
  p_one_match_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R3: not ready while a memory access is outstanding
  p_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  // R5: a fault response carries a zero page number
  p_fault_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_ppn == '0));

  // R9: write-back data always has the present bit set
  p_wb_present_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[PTE_W-1]);

  // R10: request fields hold until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
endmodule

bind ptx_tlb ptx_tlb_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .hit(hit), .match_vec(match_vec), .resp_valid(resp_valid),
  .resp_fault(resp_fault), .resp_ppn(resp_ppn), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/sim_ptx_tlb.sv
`timescale 1ns/1ps
module sim_ptx_tlb;
  localparam int VPN_W = 10;
  localparam int PPN_W = 12;
  localparam int PA_W  = 16;
  localparam int PTE_W = PPN_W + 3;
  localparam int LAT   = 3;
  localparam logic [PA_W-1:0] BASE = 16'h4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, ref_clear = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic req_ready, resp_valid, resp_fault, mem_req, mem_we;
  logic [PPN_W-1:0] resp_ppn;
  logic [PA_W-1:0]  mem_addr;
  logic [PTE_W-1:0] mem_wdata, mem_rdata;
  logic mem_ack;

  always #2 clk = ~clk;

  ptx_tlb u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_write(req_write), .ptbr(BASE),
    .ref_clear(ref_clear), .resp_valid(resp_valid), .resp_ppn(resp_ppn),
    .resp_fault(resp_fault), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [PPN_W-1:0] ppn_of(input int v);
    return PPN_W'(v) ^ 12'hA5A;
  endfunction

  function automatic logic [PTE_W-1:0] pte_of(input int v, input bit d, input bit r);
    return {1'b1, d, r, ppn_of(v)};
  endfunction

  // page table memory model: pages whose low nibble is F are not present
  logic [PTE_W-1:0] tbl [1024];
  int cnt, rd_cnt, wr_cnt;
  logic [PA_W-1:0]  last_rd_addr, last_wr_addr;
  logic [PTE_W-1:0] last_wr_data;
  logic [9:0] tidx;
  assign tidx = 10'(mem_addr - BASE);

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      cnt <= 0;
      mem_rdata <= '0;
      for (int v = 0; v < 1024; v++)
        tbl[v] <= {(v[3:0] != 4'hF), 1'b0, 1'b0, ppn_of(v)};
    end else if (mem_req && !mem_ack) begin
      if (cnt == LAT - 1) begin
        cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          tbl[tidx] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
        end else begin
          mem_rdata <= tbl[tidx];
          rd_cnt <= rd_cnt + 1;
          last_rd_addr <= mem_addr;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  int lat;
  logic [PPN_W-1:0] got_ppn;
  logic got_fault, got_rdy;

  task automatic access(input int v, input bit w);
    @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = VPN_W'(v);
    req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    got_rdy = req_ready;
    lat = 1;
    while (!resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    got_ppn = resp_ppn;
    got_fault = resp_fault;
  endtask

  task automatic miss_ok(input int v, input string tag);
    chk(lat > 1 && lat < 200, tag, "miss latency", lat, 2);
    chk(got_ppn == ppn_of(v) && !got_fault, tag, "miss ppn", got_ppn, ppn_of(v));
  endtask

  task automatic hit_ok(input int v, input string tag);
    chk(lat == 1, tag, "hit latency", lat, 1);
    chk(got_ppn == ppn_of(v) && !got_fault, tag, "hit ppn", got_ppn, ppn_of(v));
  endtask

  // vector: {vpn, write, expect hit, expect fault}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {10'd3,  1'b0, 1'b0, 1'b0},
    {10'd3,  1'b0, 1'b1, 1'b0},
    {10'd3,  1'b1, 1'b1, 1'b0},
    {10'd15, 1'b0, 1'b0, 1'b1},
    {10'd15, 1'b0, 1'b0, 1'b1},
    {10'd7,  1'b1, 1'b0, 1'b0},
    {10'd7,  1'b0, 1'b1, 1'b0},
    {10'd3,  1'b0, 1'b1, 1'b0}
  };

  initial begin
    rd_cnt = 0;
    wr_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!resp_valid, "R1", "resp_valid after reset", resp_valid, 0);
    chk(!mem_req, "R1", "mem_req after reset", mem_req, 0);
    chk(req_ready, "R1", "req_ready after reset", req_ready, 1);

    for (int i = 0; i < NV; i++) begin
      int v, rd0;
      bit w, eh, ef;
      v  = int'(VEC[i][12:3]);
      w  = VEC[i][2];
      eh = VEC[i][1];
      ef = VEC[i][0];
      rd0 = rd_cnt;
      access(v, w);
      if (ef) begin
        chk(got_fault && got_ppn == 0, "R5", "fault response", {got_fault, got_ppn}, 13'h1000);
        chk(lat > 1, "R5", "fault not cached, walks again", lat, 2);
      end else if (eh) begin
        hit_ok(v, "R2");
        chk(rd_cnt == rd0, "R2", "hit reads no memory", rd_cnt - rd0, 0);
        chk(got_rdy, "R2", "ready after hit", got_rdy, 1);
      end else begin
        miss_ok(v, "R3");
        chk(!got_rdy, "R3", "busy during walk", got_rdy, 0);
      end
      if (!eh) begin
        chk(last_rd_addr == BASE + PA_W'(v), "R3", "walk address", last_rd_addr, BASE + PA_W'(v));
        chk(rd_cnt == rd0 + 1, "R10", "one read per walk", rd_cnt - rd0, 1);
      end
    end
    chk(wr_cnt == 0, "R5", "no write while slots free", wr_cnt, 0);

    // fill remaining slots: slots 2..15 take pages 16..29
    for (int v = 16; v < 30; v++) begin
      access(v, 1'b0);
      miss_ok(v, "R8");
    end
    chk(wr_cnt == 0, "R8", "empty slots used first", wr_cnt, 0);

    // all reference bits set: rotating pointer picks slot 0 (page 3)
    access(32, 1'b0);
    miss_ok(32, "R8");
    chk(wr_cnt == 1, "R9", "changed victim written", wr_cnt, 1);
    chk(last_wr_addr == BASE + 16'd3, "R8", "pointer victim slot 0", last_wr_addr, BASE + 16'd3);
    chk(last_wr_data == pte_of(3, 1, 1), "R6", "ref and dirty in write-back", last_wr_data, pte_of(3, 1, 1));
    chk(tbl[3] == pte_of(3, 1, 1), "R4", "table slot layout", tbl[3], pte_of(3, 1, 1));

    // page 3 evicted, comes back; pointer now slot 1 (page 7)
    access(3, 1'b0);
    miss_ok(3, "R8");
    chk(wr_cnt == 2 && last_wr_addr == BASE + 16'd7, "R8", "pointer advanced to slot 1", last_wr_addr, BASE + 16'd7);
    chk(last_wr_data == pte_of(7, 1, 1), "R6", "write sets dirty", last_wr_data, pte_of(7, 1, 1));

    // clear reference bits: first clear slot (slot 0, page 32) is victim
    @(negedge clk);
    ref_clear = 1'b1;
    @(negedge clk);
    ref_clear = 1'b0;
    access(40, 1'b0);
    miss_ok(40, "R7");
    chk(wr_cnt == 3 && last_wr_addr == BASE + 16'd32, "R8", "first clear slot victim", last_wr_addr, BASE + 16'd32);
    chk(last_wr_data == pte_of(32, 0, 0), "R7", "cleared ref written back", last_wr_data, pte_of(32, 0, 0));

    // slot 1 holds page 3 loaded with bits already set: no write-back
    access(41, 1'b0);
    miss_ok(41, "R9");
    chk(wr_cnt == 3, "R9", "unchanged victim not written", wr_cnt, 3);
    chk(tbl[3] == pte_of(3, 1, 1), "R7", "clear alone not written", tbl[3], pte_of(3, 1, 1));

    access(3, 1'b0);
    miss_ok(3, "R8");
    chk(wr_cnt == 4 && last_wr_addr == BASE + 16'd16, "R8", "next clear slot victim", last_wr_addr, BASE + 16'd16);
    chk(last_wr_data == pte_of(16, 0, 0), "R9", "write-back data", last_wr_data, pte_of(16, 0, 0));

    access(41, 1'b0);
    hit_ok(41, "R2");
    access(40, 1'b1);
    hit_ok(40, "R2");

    // reset mid-run empties every slot
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req && !resp_valid, "R1", "state after second reset",
        {req_ready, mem_req, resp_valid}, 3'b100);
    access(40, 1'b0);
    miss_ok(40, "R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule